// File: doc/BRIEF.md
# Flagless Compare and Branch Unit

This unit decides compare and conditional-branch operations for a 64-bit machine with sixteen general registers and no condition-flag register. Each condition is worked out directly from the register values named by the instruction. The two operands are first narrowed to one of four widths, chosen by a 2-bit size code, and the condition is then evaluated at that width.

A request carries an operation code, two operand values, the size code, the current program counter and a signed branch offset. A compare operation yields 0 or 1 for the destination register. A branch operation yields a taken flag and the next program counter. All results are registered. A valid pulse appears on the clock edge that follows an accepted request, and the outputs hold their values until the next request arrives.

Top module: `cmpbr_unit`

## Requirements
- R1: Operation codes on `op_i`: 0 compare-equal, 1 compare-not-equal, 2 compare-less-or-equal, 3 compare-less-than, 4 branch-equal, 5 branch-not-equal, 6 branch-less-than, 7 branch-less-or-equal, 8 branch-if-zero, 9 branch-if-not-zero. Compare-equal and compare-not-equal report whether the narrowed operands match.
- R2: Less-than and less-or-equal, for both compares and branches, treat the narrowed operands as two's-complement signed values at the selected width.
- R3: Size code 0 selects 8 bits, 1 selects 16 bits, 2 selects 32 bits and 3 selects 64 bits. Operand bits above the selected width have no effect on any result.
- R4: The compare result is exactly 1 when the condition is true and 0 when it is false. Bits 63:1 of `cmp_result_o` are always 0. After a branch operation the result is 0.
- R5: Branch-equal, branch-not-equal, branch-less-than and branch-less-or-equal set `taken_o` from the comparison of operand A with operand B.
- R6: Branch-if-zero and branch-if-not-zero test only the narrowed operand A. Operand B has no effect on them.
- R7: When a branch is taken, `next_pc_o` equals `pc_i` plus `offset_i` sign-extended to 64 bits.
- R8: When a branch is not taken, and for every compare, `next_pc_o` equals `pc_i` plus 2 and `taken_o` is 0.
- R9: `valid_o` is 1 in exactly the cycle after a cycle with `req_valid_i` high. Reset clears `valid_o` and all the outputs to 0.
- R10: While `req_valid_i` is low, the result outputs keep the values of the last request.
- R11: Codes 10 to 15 are not used. Such a request still pulses `valid_o`, with result 0, `taken_o` 0, `is_branch_o` 0 and `next_pc_o` equal to `pc_i` plus 2. `is_branch_o` is 1 only for codes 4 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe; the inputs are sampled on this edge |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand width code |
| opa_i | input | 64 | Operand A (the tested register for zero branches) |
| opb_i | input | 64 | Operand B |
| pc_i | input | 64 | Current program counter |
| offset_i | input | 12 | Signed branch offset |
| valid_o | output | 1 | Result valid pulse |
| is_branch_o | output | 1 | The registered operation was a branch |
| cmp_result_o | output | 64 | Compare result, 0 or 1 |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 64 | Next program counter |

## Verification
Every result of this unit is due one clock edge after the request. The request, the size code and both operands are sampled on that edge, and the compare result, the taken flag, the next PC and the valid pulse all appear together after it, with no further latency. The bench changes its inputs on falling edges and holds a request high for one full cycle. It reads the outputs on the falling edge that follows the capturing rising edge, so each reading comes half a cycle after the registers update. Idle cycles are checked in the same way: the valid pulse must have dropped and the results must not have changed.

// File: rtl/cmpbr_pkg.sv
package cmpbr_pkg;
  localparam int XLEN    = 64;
  localparam int OP_W    = 4;
  localparam int SIZE_W  = 2;
  localparam int N_SIZES = 1 << SIZE_W;
  localparam int ILEN_B  = 2;  // bytes per instruction

  typedef enum logic [OP_W-1:0] {
    OP_CEQ = 4'd0,
    OP_CNE = 4'd1,
    OP_CLE = 4'd2,
    OP_CLT = 4'd3,
    OP_BEQ = 4'd4,
    OP_BNE = 4'd5,
    OP_BLT = 4'd6,
    OP_BLE = 4'd7,
    OP_BZ  = 4'd8,
    OP_BNZ = 4'd9
  } op_e;
endpackage

// File: rtl/cmpbr_narrow.sv
module cmpbr_narrow
  import cmpbr_pkg::*;
(
  input  logic [XLEN-1:0]   data_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [XLEN-1:0]   sext_o
);
  logic [XLEN-1:0] ext [N_SIZES];

  for (genvar s = 0; s < N_SIZES; s++) begin : g_w
    localparam int W = 8 << s;
    if (W < XLEN) begin : g_part
      assign ext[s] = {{(XLEN-W){data_i[W-1]}}, data_i[W-1:0]};
    end else begin : g_full
      assign ext[s] = data_i;
    end
  end

  assign sext_o = ext[size_i];
endmodule

// File: rtl/cmpbr_cond.sv
module cmpbr_cond
  import cmpbr_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            cmp_o,
  output logic            taken_o,
  output logic            is_branch_o
);
  logic eq, lt, zero;

  assign eq   = (a_i == b_i);
  assign lt   = ($signed(a_i) < $signed(b_i));
  assign zero = (a_i == '0);

  always_comb begin
    cmp_o       = 1'b0;
    taken_o     = 1'b0;
    is_branch_o = 1'b0;
    unique case (op_i)
      OP_CEQ: cmp_o = eq;
      OP_CNE: cmp_o = !eq;
      OP_CLE: cmp_o = lt | eq;
      OP_CLT: cmp_o = lt;
      OP_BEQ: begin is_branch_o = 1'b1; taken_o = eq;      end
      OP_BNE: begin is_branch_o = 1'b1; taken_o = !eq;     end
      OP_BLT: begin is_branch_o = 1'b1; taken_o = lt;      end
      OP_BLE: begin is_branch_o = 1'b1; taken_o = lt | eq; end
      OP_BZ:  begin is_branch_o = 1'b1; taken_o = zero;    end
      OP_BNZ: begin is_branch_o = 1'b1; taken_o = !zero;   end
      default: ;
    endcase
  end
endmodule

// File: rtl/cmpbr_pc.sv
module cmpbr_pc
  import cmpbr_pkg::*;
#(
  parameter int OFF_W = 12
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic             taken_i,
  output logic [XLEN-1:0]  next_pc_o
);
  logic [XLEN-1:0] off_sext, step;

  assign off_sext  = {{(XLEN-OFF_W){offset_i[OFF_W-1]}}, offset_i};
  assign step      = taken_i ? off_sext : XLEN'(ILEN_B);
  assign next_pc_o = pc_i + step;
endmodule

// File: rtl/cmpbr_unit.sv
module cmpbr_unit
  import cmpbr_pkg::*;
#(
  parameter int OFF_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [OP_W-1:0]     op_i,
  input  logic [SIZE_W-1:0]   size_i,
  input  logic [XLEN-1:0]     opa_i,
  input  logic [XLEN-1:0]     opb_i,
  input  logic [XLEN-1:0]     pc_i,
  input  logic [OFF_W-1:0]    offset_i,
  output logic                valid_o,
  output logic                is_branch_o,
  output logic [XLEN-1:0]     cmp_result_o,
  output logic                taken_o,
  output logic [XLEN-1:0]     next_pc_o
);
  logic [XLEN-1:0] opnd   [2];
  logic [XLEN-1:0] narrow [2];

  assign opnd[0] = opa_i;
  assign opnd[1] = opb_i;

  for (genvar i = 0; i < 2; i++) begin : g_nar
    cmpbr_narrow u_nar (
      .data_i (opnd[i]),
      .size_i (size_i),
      .sext_o (narrow[i])
    );
  end

  logic cmp_d, taken_d, br_d;
  logic [XLEN-1:0] npc_d;

  cmpbr_cond u_cond (
    .op_i        (op_i),
    .a_i         (narrow[0]),
    .b_i         (narrow[1]),
    .cmp_o       (cmp_d),
    .taken_o     (taken_d),
    .is_branch_o (br_d)
  );

  cmpbr_pc #(.OFF_W(OFF_W)) u_pc (
    .pc_i      (pc_i),
    .offset_i  (offset_i),
    .taken_i   (taken_d),
    .next_pc_o (npc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      is_branch_o  <= 1'b0;
      cmp_result_o <= '0;
      taken_o      <= 1'b0;
      next_pc_o    <= '0;
    end else begin
      valid_o <= req_valid_i;
      if (req_valid_i) begin
        is_branch_o  <= br_d;
        cmp_result_o <= XLEN'(cmp_d);
        taken_o      <= taken_d;
        next_pc_o    <= npc_d;
      end
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> valid_o);
  // R9
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !valid_o);
  // R4
  cmp_binary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_result_o[XLEN-1:1] == '0);
  // R4
  branch_no_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_branch_o |-> cmp_result_o == '0);
  // R8
  no_branch_no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_branch_o |-> !taken_o);
  // R8
  seq_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !taken_o) |-> next_pc_o == $past(pc_i) + XLEN'(ILEN_B));
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(next_pc_o) && $stable(taken_o) && $stable(cmp_result_o)));
endmodule

// File: tb/tb_cmpbr_unit.sv
module tb_cmpbr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int OFF_W = 12;

  logic clk = 0, rst_n = 0, req = 0;
  logic [3:0] op = 0;
  logic [1:0] sz = 0;
  logic [63:0] a = 0, b = 0, pc = 0;
  logic [OFF_W-1:0] off = 0;
  logic valid, is_br, taken;
  logic [63:0] res, npc;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmpbr_unit #(.OFF_W(OFF_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req), .op_i(op), .size_i(sz),
    .opa_i(a), .opb_i(b), .pc_i(pc), .offset_i(off),
    .valid_o(valid), .is_branch_o(is_br), .cmp_result_o(res),
    .taken_o(taken), .next_pc_o(npc)
  );

  function automatic logic signed [63:0] nar(logic [63:0] v, logic [1:0] s);
    case (s)
      2'd0: return {{56{v[7]}}, v[7:0]};
      2'd1: return {{48{v[15]}}, v[15:0]};
      2'd2: return {{32{v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic ref_cond(logic [3:0] o, logic [63:0] x, logic [63:0] y,
                                    logic [1:0] s);
    logic signed [63:0] p, q;
    p = nar(x, s);
    q = nar(y, s);
    case (o)
      4'd0, 4'd4: return p == q;
      4'd1, 4'd5: return p != q;
      4'd2, 4'd7: return p <= q;
      4'd3, 4'd6: return p < q;
      4'd8: return p == 0;
      4'd9: return p != 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(bit ok, string req_tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic run(logic [3:0] o, logic [1:0] s, logic [63:0] x, logic [63:0] y,
                     logic [63:0] p, logic [OFF_W-1:0] f, string tag);
    logic c, br;
    logic [63:0] e_res, e_npc;
    logic e_tk;
    @(negedge clk);
    op = o; sz = s; a = x; b = y; pc = p; off = f; req = 1;
    @(negedge clk);
    req = 0;
    c  = ref_cond(o, x, y, s);
    br = (o >= 4 && o <= 9);
    e_tk  = br & c;
    e_res = (!br && o <= 3) ? 64'(c) : 64'd0;
    e_npc = e_tk ? p + {{(64-OFF_W){f[OFF_W-1]}}, f} : p + 64'd2;
    chk(valid === 1'b1, {"R9 valid ", tag}, 64'(valid), 64'd1);
    chk(res === e_res, {"R1/R2/R3/R4 result ", tag}, res, e_res);
    chk(taken === e_tk, {"R5/R6 taken ", tag}, 64'(taken), 64'(e_tk));
    chk(is_br === br, {"R11 is_branch ", tag}, 64'(is_br), 64'(br));
    chk(npc === e_npc, {"R7/R8 next_pc ", tag}, npc, e_npc);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] h_res, h_npc;
    logic h_tk;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(valid === 0 && taken === 0 && is_br === 0, "R9 reset flags", {61'd0, valid, taken, is_br}, 0);
    chk(res === 0 && npc === 0, "R9 reset data", res | npc, 0);
    rst_n = 1;
    @(negedge clk);
    chk(valid === 0, "R9 idle after reset", 64'(valid), 0);

    // R1 equality, R3 high bits ignored
    run(4'd0, 2'd0, 64'hFFFF_0000_0000_0012, 64'h12, 64'h1000, 0, "R1 R3 ceq size0");
    run(4'd0, 2'd3, 64'hFFFF_0000_0000_0012, 64'h12, 64'h1000, 0, "R1 R3 ceq size3");
    run(4'd1, 2'd1, 64'h0001_1234, 64'h0002_1234, 64'h1000, 0, "R1 cne size1");
    // R2 signed at width
    run(4'd3, 2'd0, 64'h80, 64'h01, 64'h2000, 0, "R2 clt -128<1");
    run(4'd3, 2'd1, 64'h80, 64'h01, 64'h2000, 0, "R2 clt 128<1 false");
    run(4'd2, 2'd2, 64'h8000_0000, 64'h8000_0000, 64'h2000, 0, "R2 cle equal");
    run(4'd3, 2'd3, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, "R2 clt min<max");
    // R5 branches, R7 negative offset
    run(4'd4, 2'd2, 64'h5, 64'h5, 64'h4000, 12'hFF0, "R5 R7 beq back");
    run(4'd6, 2'd0, 64'hFF, 64'h00, 64'h4000, 12'h010, "R5 blt -1<0");
    run(4'd7, 2'd0, 64'h01, 64'hFF, 64'h4000, 12'h010, "R5 R8 ble not taken");
    run(4'd5, 2'd3, 64'h3, 64'h3, 64'hFFFF_FFFF_FFFF_FFFE, 12'h040, "R8 bne wrap");
    // R6 zero tests ignore B
    run(4'd8, 2'd0, 64'h100, 64'hDEAD, 64'h6000, 12'h7FF, "R6 bz narrow zero");
    run(4'd8, 2'd1, 64'h100, 64'h0, 64'h6000, 12'h7FF, "R6 bz nonzero");
    run(4'd9, 2'd2, 64'h1_0000_0000, 64'h1, 64'h6000, 12'h800, "R6 bnz zero at 32");
    // R11 unused codes
    run(4'd12, 2'd3, 64'h1, 64'h1, 64'h7000, 12'h100, "R11 code12");
    run(4'd15, 2'd0, 64'h0, 64'h0, 64'h7000, 12'h100, "R11 code15");

    // R10 hold across idle cycles
    h_res = res; h_npc = npc; h_tk = taken;
    @(negedge clk);
    a = 64'h1234; pc = 64'h9999; op = 4'd4;
    repeat (3) @(negedge clk);
    chk(valid === 0, "R9 no pulse when idle", 64'(valid), 0);
    chk(res === h_res && npc === h_npc && taken === h_tk, "R10 hold", npc, h_npc);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] x, y;
      logic [3:0] o;
      x = {$urandom, $urandom};
      y = ($urandom % 3 == 0) ? x ^ (64'($urandom % 2) << ($urandom % 64)) : {$urandom, $urandom};
      o = 4'($urandom % 16);
      if (o == 4'd8 || o == 4'd9) if ($urandom % 2 == 0) x = x & 64'hFFFF_FFFF_0000_0000;
      run(o, 2'($urandom), x, y, {$urandom, $urandom}, 12'($urandom), "random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule